// File: doc/BRIEF.md
# Prioritized Burst Address Counter

This block holds the address register that sits in front of one port of a dual-ported memory array. On every rising clock edge it does exactly one thing. It can clear itself to zero, take an address from the external bus, step to the next location, or keep its current value. A fixed priority settles any conflict between the three active-low controls. Clear wins over load, and load wins over increment.

A host starts a burst by strobing in a start address. It then holds the count enable low for as many cycles as it wants consecutive words. Each edge moves the registered address to the next location. The address rolls over from the top of the array back to zero, with no burst-length boundary in between. When no control is asserted the address stays where it is and the external bus is ignored, so the bus can be stalled or reused.

Top module: `burst_addr_ctr`

## Requirements
- R1: While the active-low global reset `rst_n` is low, `addr` is zero, and it is still zero on the first sample after reset is released.
- R2: If `clear_n` is low at a rising edge, `addr` is zero after that edge, whatever `load_n`, `count_n` and `ext_addr` are.
- R3: If `load_n` is low and `clear_n` is high at a rising edge, `addr` equals the `ext_addr` that was present at that edge.
- R4: If `count_n` is low and both `load_n` and `clear_n` are high at a rising edge, `addr` becomes its previous value plus one.
- R5: The increment is taken modulo 2^AW. An increment from all ones (0x7FFF at the default AW=15) gives zero.
- R6: If `clear_n`, `load_n` and `count_n` are all high at a rising edge, `addr` keeps its value and any change on `ext_addr` has no effect.
- R7: `count_n` has no effect in a cycle where `load_n` or `clear_n` is low. The result is the same as with `count_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low global reset |
| clear_n | input | 1 | Synchronous active-low counter clear (highest priority) |
| load_n | input | 1 | Active-low address strobe; loads `ext_addr` |
| count_n | input | 1 | Active-low count enable; advances the address by one |
| ext_addr | input | AW | External address bus |
| addr | output | AW | Current registered address driving the array |

## Verification
Load and increment are the two functions that most often collide. They meet whenever the strobe and the count enable are low in the same cycle. Clear can land on top of both of them as well. The bench steps through all eight patterns of the three controls, placing a nonzero pre-existing address and a fresh bus value in front of each one. A scoreboard predicts the result of each cycle from the priority order alone and flags any cycle where the address shows a step beyond the loaded value or a value that is not zero after a clear.

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_n,
  input  logic          load_n,
  input  logic          count_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ZERO = '0;
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] addr_inc;

  assign addr_inc = addr_q + ONE;

  always_comb begin
    if (!clear_n)      addr_d = ZERO;
    else if (!load_n)  addr_d = ext_addr;
    else if (!count_n) addr_d = addr_inc;
    else               addr_d = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= ZERO;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

module burst_addr_ctr_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_n,
  input logic          load_n,
  input logic          count_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] addr
);

  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (addr == '0);
  end

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> addr == '0);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> addr == $past(ext_addr));

  a_r4_r5_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !count_n) |=> addr == AW'($past(addr) + AW'(1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && count_n) |=> $stable(addr));

  a_r7_no_step_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n && !count_n) |=> addr == $past(ext_addr));

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
  .count_n(count_n), .ext_addr(ext_addr), .addr(addr)
);

// File: tb/burst_addr_ctr_tb_top.sv
module burst_addr_ctr_tb_top;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear_n = 1'b1;
  logic          load_n = 1'b1;
  logic          count_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] model = '0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
    .count_n(count_n), .ext_addr(ext_addr), .addr(addr)
  );

  task automatic check(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (addr !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h expected %h", tag, addr, exp);
    end
  endtask

  task automatic step(input bit clr, input bit ld, input bit cnt,
                      input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    clear_n = clr; load_n = ld; count_n = cnt; ext_addr = a;
    if (!clr)      model = '0;
    else if (!ld)  model = a;
    else if (!cnt) model = model + AW'(1);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 check('0, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #5 check('0, "R1 after reset");

    step(1, 0, 1, 15'h1234, "R3 load");
    step(1, 1, 1, 15'h5555, "R6 hold bus change");
    step(1, 1, 1, 15'h2AAA, "R6 hold bus change");
    step(1, 1, 0, 15'h0000, "R4 step");
    step(1, 1, 0, 15'h7777, "R4 step");
    step(1, 1, 0, 15'h0001, "R4 step");

    for (int p = 0; p < 8; p++) begin
      step(1, 0, 1, 15'h0100 + 15'(p * 16), "R3 preset");
      step(p[2], p[1], p[0], 15'h3C00 + 15'(p), (p[2] == 1'b0) ? "R2 combo" :
           (p[1] == 1'b0) ? "R7 combo" : (p[0] == 1'b0) ? "R4 combo" : "R6 combo");
    end

    step(1, 0, 1, 15'h7FFE, "R3 near top");
    step(1, 1, 0, 15'h0000, "R4 to top");
    step(1, 1, 0, 15'h1111, "R5 wrap");
    step(1, 1, 0, 15'h1111, "R5 after wrap");
    step(1, 0, 0, 15'h7FFF, "R7 load beats step");
    step(1, 1, 0, 15'h0000, "R5 wrap from load");
    step(1, 0, 1, 15'h4321, "R3 load");
    step(0, 0, 0, 15'h7FFF, "R2 clear beats all");
    step(1, 1, 1, 15'h6666, "R6 hold at zero");
    step(1, 1, 1, 15'h6666, "R6 hold");

    @(negedge clk);
    clear_n = 1'b1; load_n = 1'b1; count_n = 1'b1;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule